// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block keeps the Base Address Registers of one PCI function's configuration header. Each slot receives a template word at build time. The template works as two things at once. Its low bits give the slot's type: I/O or memory, with an address width of 16 or 32 bits for I/O and 20, 32 or 64 bits for memory. Its set bits mark which address bits software may write. The type is worked out once, at elaboration, and kept as a constant per slot. A 64-bit memory slot claims the following slot as well, and that following slot holds address bits 63:32.

Configuration software reaches the slots through a simple port. It drives a slot index, byte enables and write data, and reads the selected slot back at once. The all-ones sizing probe uses the normal write path, so there is no separate sizing mode. A write of all ones reads back as the region's size mask plus the fixed type bits. Slot 0 also drives a decoded base address output. A one-cycle notify pulse fires whenever that base takes a new value.

Top module: `pci_bar_bank`

## Requirements
- R1: After reset, every slot reads back zero in its address bits and only its fixed type bits. With the default templates, slots 0 to 5 read 0x00000000, 0x0000000C, 0x00000000, 0x00000001, 0x00000002 and 0x00000001.
- R2: A memory slot reads bit 0 as 0. It reads bits 2:1 as 00 for 32-bit, 01 for 20-bit and 10 for the lower half of a 64-bit pair. Bit 3 repeats the template's prefetch bit, and the address bits below the region size read 0. With template 0xFFFFF00C, writing 0x8000A123 reads 0x8000A00C.
- R3: An I/O slot reads bit 0 as 1 and bit 1 as 0. A 16-bit I/O slot also reads bits 31:16 as 0. Template 0x0000FF01 sized with all ones reads 0x0000FF01. Template 0xFFFFFFE1 written with 0x12345678 reads 0x12345661.
- R4: Writing 0xFFFFFFFF with all byte enables returns the region size mask ORed with the type bits. Slot 0 uses template 0xFFF80000, which asks for a 512 KiB memory region, and reads 0xFFF80000 after the probe.
- R5: A 20-bit memory slot reads bits 31:20 as 0 for any write. Template 0xFFFF0002 sized with all ones reads 0x000F0002.
- R6: The upper slot of a 64-bit pair stores all 32 written bits unmasked and has no type bits.
- R7: Only the byte lanes whose enable bit is set are written. Bit k of the byte enable covers data bits 8k+7:8k.
- R8: The base output carries slot 0's value with bits 3:0 cleared. When that masked value changes, the base output takes the new value and the notify output is high for exactly one cycle. Both happen on the second rising edge after the write.
- R9: A slot 0 write that leaves the masked base unchanged gives no notify pulse. A write to any other slot never gives one.
- R10: An index at or above the slot count reads zero, and a write to it changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the selected slot |
| cfg_idx | input | IDX_W (3) | Slot index |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read-back of the selected slot, combinational |
| bar0_base | output | 32 | Slot 0 base address, bits 3:0 cleared |
| bar0_chg | output | 1 | One-cycle pulse on a change of bar0_base |

## Verification
Sizing and base notification land on the same event when software probes slot 0 after a base has already been programmed. The probe replaces the programmed base with the size mask, so the read-back must show the mask while the notify output pulses. The bench programs a base, writes all ones, and checks three things: the read-back equals 0xFFF80000, the pulse appears in the expected cycle, and the base output holds the mask. It then writes the old base back and expects a second pulse. Partial byte-enable writes that leave the base untouched are checked for the absence of a pulse.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_IO16,
    BK_IO32,
    BK_MEM20,
    BK_MEM32,
    BK_MEM64LO,
    BK_MEM64HI
  } bar_kind_e;

  // Decide a slot's kind from its template and from its left neighbour.
  function automatic bar_kind_e classify(input logic [31:0] tmpl,
                                         input bar_kind_e prev,
                                         input logic is_last);
    bar_kind_e k;
    if (prev == BK_MEM64LO)      k = BK_MEM64HI;
    else if (tmpl == 32'h0)      k = BK_NONE;
    else if (tmpl[0])            k = (tmpl[31:16] == 16'h0) ? BK_IO16 : BK_IO32;
    else begin
      case (tmpl[2:1])
        2'b01:   k = BK_MEM20;
        2'b10:   k = is_last ? BK_MEM32 : BK_MEM64LO;
        default: k = BK_MEM32;
      endcase
    end
    return k;
  endfunction

  // Bits software may change in a slot.
  function automatic logic [31:0] wr_mask(input bar_kind_e k, input logic [31:0] tmpl);
    case (k)
      BK_IO16:              return tmpl & 32'h0000_FFFC;
      BK_IO32:              return tmpl & 32'hFFFF_FFFC;
      BK_MEM20:             return tmpl & 32'h000F_FFF0;
      BK_MEM32, BK_MEM64LO: return tmpl & 32'hFFFF_FFF0;
      BK_MEM64HI:           return 32'hFFFF_FFFF;
      default:              return 32'h0;
    endcase
  endfunction

  // Read-only type bits a slot reports in its low nibble.
  function automatic logic [31:0] fixed_bits(input bar_kind_e k, input logic [31:0] tmpl);
    case (k)
      BK_IO16, BK_IO32: return 32'h1;
      BK_MEM20:         return {28'h0, tmpl[3], 3'b010};
      BK_MEM32:         return {28'h0, tmpl[3], 3'b000};
      BK_MEM64LO:       return {28'h0, tmpl[3], 3'b100};
      default:          return 32'h0;
    endcase
  endfunction

  // Byte-lane merge of write data into an old word.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import pci_bar_pkg::*;
#(
  parameter logic [31:0] TEMPLATE = 32'h0,
  parameter bar_kind_e   KIND     = BK_NONE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val
);

  localparam logic [31:0] WMASK = wr_mask(KIND, TEMPLATE);
  localparam logic [31:0] FIXED = fixed_bits(KIND, TEMPLATE);

  logic [31:0] addr_q;
  logic [31:0] addr_nxt;

  // Sizing probes and normal writes share this one path.
  assign addr_nxt = lane_merge(addr_q, wdata, be) & WMASK;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= 32'h0;
    else if (wr_en) addr_q <= addr_nxt;
  end

  assign rd_val = addr_q | FIXED;

  genvar b;
  generate
    for (b = 0; b < 4; b++) begin : g_lane_chk
      a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[b]) |=> $stable(rd_val[8*b +: 8]));
    end
  endgenerate

  a_r6_upper_full: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == BK_MEM64HI && wr_en && be == 4'hF) |=> rd_val == $past(wdata));

endmodule

// File: rtl/bar0_notify.sv
module bar0_notify (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] bar0_val,
  output logic [31:0] base,
  output logic        chg
);

  logic [31:0] base_q;
  logic        chg_q;
  logic [31:0] seen_base;
  logic        base_moved;

  assign seen_base  = bar0_val & 32'hFFFF_FFF0;
  assign base_moved = seen_base != base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= 32'h0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= base_moved;
      if (base_moved) base_q <= seen_base;
    end
  end

  assign base = base_q;
  assign chg  = chg_q;

  a_r8_chg_moves_base: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> base != $past(base));

  a_r9_chg_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> $past(wr_hit, 2));

endmodule

// File: rtl/pci_bar_bank.sv
module pci_bar_bank
  import pci_bar_pkg::*;
#(
  parameter int unsigned NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_TEMPLATE = {
    32'hFFFF_FFE1,   // slot 5: 32-bit I/O, 32 bytes
    32'hFFFF_0002,   // slot 4: 20-bit memory, 64 KiB
    32'h0000_FF01,   // slot 3: 16-bit I/O, 256 bytes
    32'hFFFF_FFFF,   // slot 2: upper half of the pair
    32'hFFFF_F00C,   // slot 1: 64-bit prefetchable memory, 4 KiB
    32'hFFF8_0000    // slot 0: 32-bit memory, 512 KiB
  },
  localparam int unsigned IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic [31:0]      bar0_base,
  output logic             bar0_chg
);

  // Walk the slots left to right so that a 64-bit lower half claims its neighbour.
  function automatic bar_kind_e slot_kind(input int s);
    bar_kind_e prev = BK_NONE;
    bar_kind_e k    = BK_NONE;
    for (int j = 0; j <= s; j++) begin
      k    = classify(BAR_TEMPLATE[j*32 +: 32], prev, j == NUM_BARS - 1);
      prev = k;
    end
    return k;
  endfunction

  logic [NUM_BARS-1:0][31:0] rd_all;
  logic [NUM_BARS-1:0]       wr_sel;
  logic                      idx_ok;

  assign idx_ok = {{(32-IDX_W){1'b0}}, cfg_idx} < NUM_BARS;

  genvar i;
  generate
    for (i = 0; i < NUM_BARS; i++) begin : g_slot
      assign wr_sel[i] = cfg_wr && (cfg_idx == IDX_W'(i));
      bar_slot #(
        .TEMPLATE (BAR_TEMPLATE[i*32 +: 32]),
        .KIND     (slot_kind(i))
      ) i_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_sel[i]),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .rd_val (rd_all[i])
      );
    end
  endgenerate

  always_comb begin
    cfg_rdata = 32'h0;
    for (int s = 0; s < NUM_BARS; s++)
      if (idx_ok && cfg_idx == IDX_W'(s)) cfg_rdata = rd_all[s];
  end

  bar0_notify i_notify (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_sel[0]),
    .bar0_val (rd_all[0]),
    .base     (bar0_base),
    .chg      (bar0_chg)
  );

  a_r10_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !idx_ok) |=> $stable(rd_all));

  a_r10_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> cfg_rdata == 32'h0);

endmodule

// File: tb/test_pci_bar_bank.sv
module test_pci_bar_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] bar0_base;
  logic        bar0_chg;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pci_bar_bank i_pci_bar_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .bar0_base (bar0_base),
    .bar0_chg  (bar0_chg)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_chg;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'hF, 32'hFFFF_FFFF, 32'hFFF8_0000, 1'b1, 8'd4},  // R4 sizing probe
    '{3'd0, 4'hF, 32'h1234_5678, 32'h1230_0000, 1'b1, 8'd8},  // R8 new base
    '{3'd0, 4'hF, 32'h1230_0000, 32'h1230_0000, 1'b0, 8'd9},  // R9 same base
    '{3'd0, 4'h8, 32'hAB00_0000, 32'hAB30_0000, 1'b1, 8'd7},  // R7 top lane only
    '{3'd0, 4'h1, 32'h0000_00FF, 32'hAB30_0000, 1'b0, 8'd7},  // R7 lane 0 only
    '{3'd1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_F00C, 1'b0, 8'd2},  // R2 64-bit lower
    '{3'd2, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 8'd6},  // R6 upper
    '{3'd2, 4'hF, 32'h0000_0001, 32'h0000_0001, 1'b0, 8'd6},  // R6 upper low bit
    '{3'd1, 4'hF, 32'h8000_A123, 32'h8000_A00C, 1'b0, 8'd2},  // R2 low bits
    '{3'd3, 4'hF, 32'hFFFF_FFFF, 32'h0000_FF01, 1'b0, 8'd3},  // R3 16-bit I/O
    '{3'd4, 4'hF, 32'hFFFF_FFFF, 32'h000F_0002, 1'b0, 8'd5},  // R5 20-bit mem
    '{3'd5, 4'hF, 32'h1234_5678, 32'h1234_5661, 1'b0, 8'd3},  // R3 32-bit I/O
    '{3'd5, 4'h3, 32'h0000_FFFF, 32'h1234_FFE1, 1'b0, 8'd7}   // R7 two lanes
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Write, then sample on the falling edge after the second rising edge.
  task automatic do_write(input logic [2:0] idx, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    cfg_idx = idx; cfg_be = be; cfg_wdata = wd; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_at(input logic [2:0] idx, output logic [31:0] v);
    cfg_idx = idx;
    #1;
    v = cfg_rdata;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] rst_exp [6];
    rst_exp = '{32'h0, 32'hC, 32'h0, 32'h1, 32'h2, 32'h1};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of every slot
    for (int s = 0; s < 6; s++) begin
      read_at(3'(s), v);
      check("R1", $sformatf("reset slot %0d", s), v, rst_exp[s]);
    end
    check("R1", "reset base", bar0_base, 32'h0);
    check("R1", "reset notify", {31'h0, bar0_chg}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k].idx, VEC[k].be, VEC[k].wd);
      check($sformatf("R%0d", VEC[k].req), "notify", {31'h0, bar0_chg}, {31'h0, VEC[k].exp_chg});
      read_at(VEC[k].idx, v);
      check($sformatf("R%0d", VEC[k].req), $sformatf("vec %0d read", k), v, VEC[k].exp_rd);
    end

    // R8 base output and single-cycle pulse
    check("R8", "base after table", bar0_base, 32'hAB30_0000);
    @(negedge clk);
    check("R8", "pulse width", {31'h0, bar0_chg}, 32'h0);

    // R10 index beyond the bank
    do_write(3'd6, 4'hF, 32'hFFFF_FFFF);
    read_at(3'd6, v);
    check("R10", "oob read", v, 32'h0);
    check("R10", "oob notify", {31'h0, bar0_chg}, 32'h0);
    read_at(3'd0, v);
    check("R10", "slot0 after oob", v, 32'hAB30_0000);
    read_at(3'd5, v);
    check("R10", "slot5 after oob", v, 32'h1234_FFE1);

    // R4 + R8 sizing probe over a programmed base
    do_write(3'd0, 4'hF, 32'hFFFF_FFFF);
    check("R8", "probe notify", {31'h0, bar0_chg}, 32'h1);
    check("R8", "probe base", bar0_base, 32'hFFF8_0000);
    read_at(3'd0, v);
    check("R4", "probe read", v, 32'hFFF8_0000);
    do_write(3'd0, 4'hF, 32'hAB30_0000);
    check("R8", "restore notify", {31'h0, bar0_chg}, 32'h1);
    check("R8", "restore base", bar0_base, 32'hAB30_0000);

    // R9 a 64-bit upper write moves no base
    do_write(3'd2, 4'hF, 32'h0000_0000);
    check("R9", "upper write notify", {31'h0, bar0_chg}, 32'h0);

    // R1 reset again mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_at(3'd0, v);
    check("R1", "re-reset slot0", v, 32'h0);
    read_at(3'd4, v);
    check("R1", "re-reset slot4", v, 32'h2);
    check("R1", "re-reset base", bar0_base, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule